// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Registers

This block is the register front end of a flash-style controller. Software reaches it through a synchronous 16-bit port with word offsets. Through that port it sets up two configuration words and a buffer-select/sector-count word, writes command codes, and reads back the controller error flags and the interrupt flags. The block decodes each command code. A known operation raises a one-cycle start pulse to an external command engine. A reset code reinitialises the registers. Any other code is flagged as an error.

When the engine finishes an operation it returns a completion class (load, program, erase or reset) and an error flag. The block turns this report into interrupt and error bits. It drives a level interrupt whose polarity a configuration bit selects, and a ready output that follows another configuration bit. Software acknowledges an interrupt by writing an AND mask into the interrupt register. While the global interrupt flag is still set, new commands are refused.

Top module: `flash_irq_regs`

## Requirements
- R1: After the asynchronous reset, the registers read back as follows: command 0x0000, configuration 1 0x40C0, configuration 2 0x0000, status 0x0000, interrupt 0x8080, buffer 0x0000. The ready output is 1. Word offsets: 0 command, 1 configuration 1, 2 configuration 2, 3 buffer, 4 status (read only), 5 interrupt.
- R2: A buffer write takes the buffer number from bits 11:8 and the sector count from bits 1:0, where 0 means 4. Readback puts the buffer number in bits 11:8 and returns (count-1) masked to bit 1 in the low bits.
- R3: Configuration 1 reads back with bits 4:0 forced to zero. The ready output takes bit 7 of each value written to it. Configuration 2 reads back as written. Writes to the status offset have no effect.
- R4: The interrupt output equals interrupt bit 15 XOR the inverse of configuration 1 bit 6. With bit 6 at 1 the interrupt is active high; with bit 6 at 0 it is active low.
- R5: A command write is ignored while interrupt bit 15 is set. The command register keeps its value and no start pulse is issued.
- R6: An accepted known command code is latched into the command register. In the following cycle, cmd_start is high for one cycle and cmd_code shows that code.
- R7: An accepted unknown command code sets status bit 10 and interrupt bit 15, and issues no start pulse.
- R8: A completion report sets interrupt bit 15 together with its class bit: load bit 7, program bit 6, erase bit 5, reset bit 4. The class encoding is load 0, program 1, erase 2, reset 3. When the report carries an error, it sets status bit 10 and the class error bit: load 13, program 12, erase 11; reset sets bit 10 only.
- R9: A write to the interrupt register ANDs the written value into its contents.
- R10: If interrupt bit 15 is clear after an interrupt write, status bits 13:10 are cleared.
- R11: A completion report in the same cycle as an interrupt AND-clear wins: its bits stay set, and its error bits survive.
- R12: A warm reset, either from the warm_rst input or from an accepted command 0x00F0 or 0x00F3, returns the registers to their R1 values. The exception is the interrupt register, which becomes 0x8010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| warm_rst | input | 1 | Synchronous warm reset request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| done_valid | input | 1 | Command engine completion report |
| done_class | input | 2 | Completion class (0 load, 1 program, 2 erase, 3 reset) |
| done_err | input | 1 | Completed operation failed |
| cmd_start | output | 1 | One-cycle launch pulse to the command engine |
| cmd_code | output | 16 | Current command register value |
| buf_sel | output | 4 | Selected buffer |
| sec_count | output | 3 | Sector count, 1 to 4 |
| irq | output | 1 | Level interrupt, polarity per configuration 1 bit 6 |
| ready | output | 1 | Ready output |

## Verification
The hardest case to reach from the ports is a completion report that lands in the same cycle as a software AND-clear of the interrupt register. In that cycle two sources update the same bits, and the error-wipe rule must not throw away a new error. The bench raises done_valid and the interrupt write strobe at the same falling edge, so both are sampled at one rising edge. It then reads the interrupt and status words. A second awkward case is the refused command: it has to be issued while the global flag is still pending from an earlier completion, and its effect can only be confirmed by the absence of a start pulse and an unchanged command readback.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;

  localparam int DW    = 16;
  localparam int OFF_W = 3;

  typedef enum logic [OFF_W-1:0] {
    OFF_CMD  = 3'd0,
    OFF_CFG1 = 3'd1,
    OFF_CFG2 = 3'd2,
    OFF_BUF  = 3'd3,
    OFF_STAT = 3'd4,
    OFF_INT  = 3'd5
  } reg_off_e;

  typedef enum logic [1:0] {
    CLS_LOAD  = 2'd0,
    CLS_PROG  = 2'd1,
    CLS_ERASE = 2'd2,
    CLS_RESET = 2'd3
  } done_class_e;

  // interrupt bit positions
  localparam int IB_GLOBAL = 15;
  localparam int IB_LOAD   = 7;
  localparam int IB_PROG   = 6;
  localparam int IB_ERASE  = 5;
  localparam int IB_RESET  = 4;

  // status bit positions
  localparam int SB_CMD   = 10;
  localparam int SB_ERASE = 11;
  localparam int SB_PROG  = 12;
  localparam int SB_LOAD  = 13;
  localparam logic [DW-1:0] ERR_MASK = 16'h3C00;

  localparam logic [DW-1:0] INT_COLD = 16'h8080;
  localparam logic [DW-1:0] INT_WARM = 16'h8010;
  localparam logic [DW-1:0] CFG1_RST = 16'h40C0;
  localparam logic [DW-1:0] CFG1_RDMASK = 16'hFFE0;

  localparam int N_LAUNCH = 15;
  localparam logic [DW-1:0] LAUNCH_CODES [N_LAUNCH] = '{
    16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
    16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071,
    16'h0094, 16'h0095, 16'h00B0, 16'h0030, 16'h0065
  };
  localparam logic [DW-1:0] RESET_CODE_A = 16'h00F0;
  localparam logic [DW-1:0] RESET_CODE_B = 16'h00F3;

endpackage

// File: rtl/flash_irq_cmd_decode.sv
module flash_irq_cmd_decode
  import flash_irq_pkg::*;
(
  input  logic [DW-1:0] code,
  output logic          launch,
  output logic          soft_reset,
  output logic          unknown
);

  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < N_LAUNCH; i++) begin
      if (code == LAUNCH_CODES[i]) hit = 1'b1;
    end
  end

  assign soft_reset = (code == RESET_CODE_A) || (code == RESET_CODE_B);
  assign launch     = hit;
  assign unknown    = !hit && !soft_reset;

endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status
  import flash_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warm_clr,
  input  logic          int_wr,
  input  logic [DW-1:0] wdata,
  input  logic          done_valid,
  input  logic [1:0]    done_class,
  input  logic          done_err,
  input  logic          unk_set,
  output logic [DW-1:0] int_q,
  output logic [DW-1:0] stat_q
);

  logic [DW-1:0] set_int, set_err, int_and, int_d, stat_d;
  logic          err_clear, upd;
  done_class_e   cls;

  assign cls = done_class_e'(done_class);

  always_comb begin
    set_int = '0;
    set_err = '0;
    if (done_valid) begin
      set_int[IB_GLOBAL] = 1'b1;
      case (cls)
        CLS_LOAD:  set_int[IB_LOAD]  = 1'b1;
        CLS_PROG:  set_int[IB_PROG]  = 1'b1;
        CLS_ERASE: set_int[IB_ERASE] = 1'b1;
        default:   set_int[IB_RESET] = 1'b1;
      endcase
      if (done_err) begin
        set_err[SB_CMD] = 1'b1;
        case (cls)
          CLS_LOAD:  set_err[SB_LOAD]  = 1'b1;
          CLS_PROG:  set_err[SB_PROG]  = 1'b1;
          CLS_ERASE: set_err[SB_ERASE] = 1'b1;
          default:   ;
        endcase
      end
    end
    if (unk_set) begin
      set_int[IB_GLOBAL] = 1'b1;
      set_err[SB_CMD]    = 1'b1;
    end
    int_and   = int_wr ? (int_q & wdata) : int_q;
    int_d     = int_and | set_int;
    err_clear = int_wr && !int_d[IB_GLOBAL];
    stat_d    = (err_clear ? (stat_q & ~ERR_MASK) : stat_q) | set_err;
    if (warm_clr) begin
      int_d  = INT_WARM;
      stat_d = '0;
    end
  end

  assign upd = warm_clr | int_wr | done_valid | unk_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= INT_COLD;
      stat_q <= '0;
    end else if (upd) begin
      int_q  <= int_d;
      stat_q <= stat_d;
    end
  end

endmodule

// File: rtl/flash_irq_cfg.sv
module flash_irq_cfg
  import flash_irq_pkg::*;
#(
  parameter int PAGE_SHIFT = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warm_clr,
  input  logic          cfg1_wr,
  input  logic          cfg2_wr,
  input  logic          buf_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cfg1_q,
  output logic [DW-1:0] cfg2_q,
  output logic [3:0]    buf_sel,
  output logic [2:0]    sec_cnt,
  output logic          ready,
  output logic [DW-1:0] buf_rd
);

  localparam logic [DW-1:0] CNT_MASK = DW'(1 << (PAGE_SHIFT - 10));

  logic [DW-1:0] cfg1_d, cfg2_d, cnt_m1;
  logic [3:0]    buf_d;
  logic [2:0]    cnt_d, cnt_wr;
  logic          rdy_d, upd;

  generate
    if (PAGE_SHIFT == 11) begin : g_big_page
      assign cnt_wr = (wdata[1:0] == 2'd0) ? 3'd4 : {1'b0, wdata[1:0]};
    end else begin : g_small_page
      assign cnt_wr = wdata[0] ? 3'd1 : 3'd2;
    end
  endgenerate

  always_comb begin
    cfg1_d = cfg1_q;
    cfg2_d = cfg2_q;
    buf_d  = buf_sel;
    cnt_d  = sec_cnt;
    rdy_d  = ready;
    if (warm_clr) begin
      cfg1_d = CFG1_RST;
      cfg2_d = '0;
      buf_d  = '0;
      cnt_d  = 3'd1;
      rdy_d  = 1'b1;
    end else begin
      if (cfg1_wr) begin
        cfg1_d = wdata;
        rdy_d  = wdata[7];
      end
      if (cfg2_wr) cfg2_d = wdata;
      if (buf_wr) begin
        buf_d = wdata[11:8];
        cnt_d = cnt_wr;
      end
    end
  end

  assign upd = warm_clr | cfg1_wr | cfg2_wr | buf_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg1_q  <= CFG1_RST;
      cfg2_q  <= '0;
      buf_sel <= '0;
      sec_cnt <= 3'd1;
      ready   <= 1'b1;
    end else if (upd) begin
      cfg1_q  <= cfg1_d;
      cfg2_q  <= cfg2_d;
      buf_sel <= buf_d;
      sec_cnt <= cnt_d;
      ready   <= rdy_d;
    end
  end

  assign cnt_m1 = {13'd0, sec_cnt} - 16'd1;
  assign buf_rd = {4'h0, buf_sel, 8'h00} | (cnt_m1 & CNT_MASK);

endmodule

// File: rtl/flash_irq_regs.sv
module flash_irq_regs
  import flash_irq_pkg::*;
#(
  parameter int PAGE_SHIFT = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        warm_rst,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        done_valid,
  input  logic [1:0]  done_class,
  input  logic        done_err,
  output logic        cmd_start,
  output logic [15:0] cmd_code,
  output logic [3:0]  buf_sel,
  output logic [2:0]  sec_count,
  output logic        irq,
  output logic        ready
);

  logic [DW-1:0] int_q, stat_q, cfg1_q, cfg2_q, buf_rd, cmd_q, cmd_d;
  logic dec_launch, dec_reset, dec_unknown;
  logic cmd_ok, soft_rst, unk_set, start_d;

  assign cmd_ok = reg_wr && (reg_addr == OFF_CMD) && !int_q[IB_GLOBAL];

  flash_irq_cmd_decode u_dec (
    .code       (reg_wdata),
    .launch     (dec_launch),
    .soft_reset (dec_reset),
    .unknown    (dec_unknown)
  );

  assign soft_rst = warm_rst | (cmd_ok & dec_reset);
  assign unk_set  = cmd_ok & dec_unknown & !warm_rst;
  assign start_d  = cmd_ok & dec_launch & !warm_rst;

  flash_irq_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm_clr   (soft_rst),
    .int_wr     (reg_wr && (reg_addr == OFF_INT)),
    .wdata      (reg_wdata),
    .done_valid (done_valid),
    .done_class (done_class),
    .done_err   (done_err),
    .unk_set    (unk_set),
    .int_q      (int_q),
    .stat_q     (stat_q)
  );

  flash_irq_cfg #(.PAGE_SHIFT(PAGE_SHIFT)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .warm_clr (soft_rst),
    .cfg1_wr  (reg_wr && (reg_addr == OFF_CFG1)),
    .cfg2_wr  (reg_wr && (reg_addr == OFF_CFG2)),
    .buf_wr   (reg_wr && (reg_addr == OFF_BUF)),
    .wdata    (reg_wdata),
    .cfg1_q   (cfg1_q),
    .cfg2_q   (cfg2_q),
    .buf_sel  (buf_sel),
    .sec_cnt  (sec_count),
    .ready    (ready),
    .buf_rd   (buf_rd)
  );

  always_comb begin
    cmd_d = cmd_q;
    if (soft_rst)    cmd_d = '0;
    else if (cmd_ok) cmd_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      cmd_start <= 1'b0;
    end else begin
      if (soft_rst || cmd_ok) cmd_q <= cmd_d;
      cmd_start <= start_d;
    end
  end

  assign cmd_code = cmd_q;
  assign irq      = int_q[IB_GLOBAL] ^ ~cfg1_q[6];

  always_comb begin
    case (reg_addr)
      OFF_CMD:  reg_rdata = cmd_q;
      OFF_CFG1: reg_rdata = cfg1_q & CFG1_RDMASK;
      OFF_CFG2: reg_rdata = cfg2_q;
      OFF_BUF:  reg_rdata = buf_rd;
      OFF_STAT: reg_rdata = stat_q;
      OFF_INT:  reg_rdata = int_q;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/flash_irq_chk.sv
module flash_irq_chk
  import flash_irq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        warm_rst,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        done_valid,
  input logic        cmd_start,
  input logic [15:0] int_q,
  input logic [15:0] stat_q,
  input logic        dec_unknown,
  input logic        soft_rst
);

  // R5: refused command yields no launch
  p_refuse_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_CMD && int_q[15]) |=> !cmd_start);

  // R6: a launch always follows an accepted command write
  p_start_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> $past(reg_wr && reg_addr == OFF_CMD && !int_q[15]));

  // R7: unknown code flags error and global interrupt
  p_unknown_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_CMD && !int_q[15] && dec_unknown && !warm_rst)
      |=> (int_q[15] && stat_q[10]));

  // R8: completion raises the global flag
  p_done_global_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !soft_rst) |=> int_q[15]);

  // R9: AND-clear of the interrupt register
  p_and_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_INT && !done_valid && !soft_rst)
      |=> (int_q == ($past(int_q) & $past(reg_wdata))));

  // R10: no error flag survives without the global flag
  p_err_needs_global_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !int_q[15] |-> (stat_q[13:10] == 4'h0));

  // R12: warm reset value of the interrupt register
  p_warm_value_r12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (int_q == 16'h8010 && stat_q == 16'h0000));

endmodule

bind flash_irq_regs flash_irq_chk u_chk (.*);

// File: tb/flash_irq_regs_test.sv
module flash_irq_regs_test;

  logic        clk = 1'b0;
  logic        rst_n, warm_rst, reg_wr, done_valid, done_err;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata, cmd_code;
  logic [1:0]  done_class;
  logic        cmd_start, irq, ready;
  logic [3:0]  buf_sel;
  logic [2:0]  sec_count;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_irq_regs uut (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .done_valid(done_valid), .done_class(done_class), .done_err(done_err),
    .cmd_start(cmd_start), .cmd_code(cmd_code), .buf_sel(buf_sel),
    .sec_count(sec_count), .irq(irq), .ready(ready)
  );

  localparam logic [2:0] A_CMD = 3'd0, A_CFG1 = 3'd1, A_CFG2 = 3'd2,
                         A_BUF = 3'd3, A_STAT = 3'd4, A_INT = 3'd5;

  // {write offset, write data, read offset, expected read}
  localparam int NV = 13;
  localparam logic [37:0] VEC [NV] = '{
    {3'd2, 16'h1234, 3'd2, 16'h1234},  // R3 cfg2 plain
    {3'd1, 16'h40DF, 3'd1, 16'h40C0},  // R3 low bits masked
    {3'd1, 16'hC0FF, 3'd1, 16'hC0E0},  // R3
    {3'd3, 16'h0A01, 3'd3, 16'h0A00},  // R2 count 1
    {3'd3, 16'h0F00, 3'd3, 16'h0F02},  // R2 count 4
    {3'd3, 16'h0303, 3'd3, 16'h0302},  // R2 count 3
    {3'd3, 16'h0502, 3'd3, 16'h0500},  // R2 count 2
    {3'd3, 16'hF5FF, 3'd3, 16'h0502},  // R2 upper bits dropped
    {3'd5, 16'hFFFF, 3'd5, 16'h8080},  // R9 AND keeps
    {3'd5, 16'h7FFF, 3'd5, 16'h0080},  // R9 AND clears bit 15
    {3'd0, 16'h0094, 3'd0, 16'h0094},  // R6 accepted
    {3'd4, 16'hFFFF, 3'd4, 16'h0000},  // R3 status write ignored
    {3'd1, 16'h40C0, 3'd1, 16'h40C0}   // R3 restore
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic done(input logic [1:0] c, input logic e);
    @(negedge clk);
    done_valid = 1'b1; done_class = c; done_err = e;
    @(negedge clk);
    done_valid = 1'b0; done_err = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; warm_rst = 1'b0; reg_wr = 1'b0; reg_addr = '0;
    reg_wdata = '0; done_valid = 1'b0; done_class = '0; done_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CMD, v);  chk("R1 cmd", v, 16'h0000);
    rd(A_CFG1, v); chk("R1 cfg1", v, 16'h40C0);
    rd(A_CFG2, v); chk("R1 cfg2", v, 16'h0000);
    rd(A_STAT, v); chk("R1 status", v, 16'h0000);
    rd(A_INT, v);  chk("R1 int", v, 16'h8080);
    rd(A_BUF, v);  chk("R1 buf", v, 16'h0000);
    chk("R1 ready", {15'd0, ready}, 16'd1);
    chk("R4 irq after reset", {15'd0, irq}, 16'd1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][37:35], VEC[i][34:19]);
      rd(VEC[i][18:16], v);
      chk($sformatf("R2/R3/R6/R9 vector %0d", i), v, VEC[i][15:0]);
    end

    // R3 ready follows bit 7
    wr(A_CFG1, 16'h4040); chk("R3 ready low", {15'd0, ready}, 16'd0);
    wr(A_CFG1, 16'h40C0); chk("R3 ready high", {15'd0, ready}, 16'd1);

    // R4 polarity (int bit 15 is clear now)
    chk("R4 irq active high idle", {15'd0, irq}, 16'd0);
    wr(A_CFG1, 16'h0080); chk("R4 irq active low idle", {15'd0, irq}, 16'd1);
    wr(A_CFG1, 16'h40C0);

    // R6 start pulse
    wr(A_CMD, 16'h0013);
    chk("R6 start pulse", {15'd0, cmd_start}, 16'd1);
    chk("R6 cmd_code", cmd_code, 16'h0013);
    @(negedge clk);
    chk("R6 pulse one cycle", {15'd0, cmd_start}, 16'd0);

    // R8 program done, no error
    wr(A_INT, 16'h0000);
    done(2'd1, 1'b0);
    rd(A_INT, v);  chk("R8 program done", v, 16'h8040);
    rd(A_STAT, v); chk("R8 no error", v, 16'h0000);
    chk("R4 irq asserted", {15'd0, irq}, 16'd1);

    // R5 refused command
    wr(A_CMD, 16'h0000);
    chk("R5 no start", {15'd0, cmd_start}, 16'd0);
    rd(A_CMD, v); chk("R5 cmd kept", v, 16'h0013);

    // R8 load error, R9 partial clear, R10 error wipe
    done(2'd0, 1'b1);
    rd(A_INT, v);  chk("R8 load done", v, 16'h80C0);
    rd(A_STAT, v); chk("R8 load error", v, 16'h2400);
    wr(A_INT, 16'hFFBF);
    rd(A_INT, v);  chk("R9 partial clear", v, 16'h8080);
    rd(A_STAT, v); chk("R10 errors kept", v, 16'h2400);
    wr(A_INT, 16'h7FFF);
    rd(A_INT, v);  chk("R9 global clear", v, 16'h0080);
    rd(A_STAT, v); chk("R10 errors wiped", v, 16'h0000);

    // R11 done beats same-cycle clear
    wr(A_INT, 16'h0000);
    @(negedge clk);
    reg_addr = A_INT; reg_wdata = 16'h0000; reg_wr = 1'b1;
    done_valid = 1'b1; done_class = 2'd2; done_err = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; done_valid = 1'b0; done_err = 1'b0;
    rd(A_INT, v);  chk("R11 erase done kept", v, 16'h8020);
    rd(A_STAT, v); chk("R11 erase error kept", v, 16'h0C00);

    // R8 reset class
    wr(A_INT, 16'h0000);
    done(2'd3, 1'b1);
    rd(A_INT, v);  chk("R8 reset class", v, 16'h8010);
    rd(A_STAT, v); chk("R8 reset class error", v, 16'h0400);

    // R7 unknown command
    wr(A_INT, 16'h0000);
    wr(A_CMD, 16'h0055);
    chk("R7 no start", {15'd0, cmd_start}, 16'd0);
    rd(A_STAT, v); chk("R7 status", v, 16'h0400);
    rd(A_INT, v);  chk("R7 int", v, 16'h8000);

    // R12 command reset
    wr(A_INT, 16'h0000);
    wr(A_CFG2, 16'h1234);
    wr(A_BUF, 16'h0701);
    wr(A_CMD, 16'h00F0);
    chk("R12 no start", {15'd0, cmd_start}, 16'd0);
    rd(A_INT, v);  chk("R12 int", v, 16'h8010);
    rd(A_CFG2, v); chk("R12 cfg2", v, 16'h0000);
    rd(A_CMD, v);  chk("R12 cmd", v, 16'h0000);
    rd(A_BUF, v);  chk("R12 buf", v, 16'h0000);

    // R12 warm reset input
    wr(A_INT, 16'h0000);
    wr(A_CFG1, 16'h0000);
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0;
    rd(A_INT, v);  chk("R12 warm int", v, 16'h8010);
    rd(A_CFG1, v); chk("R12 warm cfg1", v, 16'h40C0);
    chk("R12 warm ready", {15'd0, ready}, 16'd1);

    finished = 1'b1;
    summary();
  end

endmodule